// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block controls how a processor core enters an interrupt handler. At each instruction boundary it compares a 3-bit incoming interrupt level against the mask field of the status register. When the level wins, it captures the current PC, status word and stack pointer. It then drives a fixed series of word-wide bus cycles: three stack writes that bracket an acknowledge cycle, followed by two reads that fetch the handler address from an autovector slot. Each bus cycle waits for the bus master's done strobe.

When the fetch completes, the block samples the level again before the handler's first instruction can run. It compares this sample with the freshly raised mask. A higher pending request starts a nested entry at once. That nested entry stacks the handler address that was just fetched as its return point, so no handler instruction runs in between. A static mode input disables this chaining, so that one handler instruction always runs first. When no further entry follows, the block pulses a completion strobe that carries the handler address, the new status word and the lowered stack pointer for the fetch unit.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, an entry starts only in a cycle where `boundary_i` is high and the incoming level is strictly greater than status bits [10:8]. Otherwise no bus cycle is issued and no completion is reported.
- R2: Level 7 is taken whatever the mask, once per arrival. Each rise of the level to 7 may start one entry. A level held at 7 under a mask of 7 does not start a second entry.
- R3: For captured level L, PC, SR and SP, the bus cycles come in this order. First, a write of PC[15:0] at SP-2. Second, an acknowledge cycle (`bus_ack_o`=1, `bus_we_o`=0) at address 0xFFFFFFF0 with bits [3:1]=L and bit 0=1. Third, a write of SR at SP-6. Fourth, a write of PC[31:16] at SP-4. Fifth, a read at V+2, then a read at V, where V = VEC_BASE + 4*(24+L).
- R4: Each bus cycle keeps `bus_req_o` high, with a stable address, until `bus_done_i` is sampled high. Any number of wait cycles gives the same sequence.
- R5: The sequence cannot be interrupted. A level change after the start does not alter any of the six bus cycles of the entry in progress.
- R6: Completion is a one-cycle `entry_done_o` pulse. `handler_o` is {word read at V, word read at V+2}. `sp_o` is the captured SP minus 6. `sr_o` is the captured SR with bit 15 cleared, bit 13 set and bits [10:8]=L. The block is idle in the following cycle.
- R7: When `one_insn_i`=0 and the level after the fetch exceeds the new mask, a nested entry starts with no completion pulse in between. It stacks the previous handler address as PC and the previous new status word as SR, and it uses the lowered SP.
- R8: When `one_insn_i`=1, no nested entry starts at the end of a sequence. Completion is always reported, and a pending level is taken only at a later boundary.
- R9: After reset the block is idle, with `busy_o`, `bus_req_o` and `entry_done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Current instruction has completed |
| level_i | input | 3 | Incoming interrupt level |
| sr_i | input | 16 | Current status register |
| sp_i | input | 32 | Current supervisor stack pointer |
| pc_i | input | 32 | Return PC of the next instruction |
| one_insn_i | input | 1 | Force one handler instruction before another entry |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_ack_o | output | 1 | Bus cycle is the interrupt acknowledge |
| bus_addr_o | output | 32 | Bus byte address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data |
| bus_done_i | input | 1 | Current bus cycle has finished |
| busy_o | output | 1 | Entry sequence in progress |
| entry_done_o | output | 1 | One-cycle completion pulse |
| handler_o | output | 32 | Fetched handler address |
| sr_o | output | 16 | New status register |
| sp_o | output | 32 | Stack pointer after the frame |

## Verification
Every pairing of the eight mask values with the eight levels is tried. The bus latency rotates from zero to two wait cycles, so the strict greater-than rule, the level-7 override and the tolerance to wait states are each separated from the others. Stack addresses and vector addresses are recomputed arithmetically for each pairing. A level raised in the middle of an entry tells the atomic frame apart from the chained one that follows it. The same stimulus with the single-instruction mode set shows that chaining is off. A level held at 7 against a mask of 7, and then dropped and raised again, shows that the override acts once per arrival.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int ADDR_W        = 32;
  localparam int WORD_W        = 16;
  localparam int LVL_W         = 3;
  localparam int SR_T_BIT      = 15;
  localparam int SR_S_BIT      = 13;
  localparam int SR_MASK_LSB   = 8;
  localparam int AUTOVEC_FIRST = 24;
  localparam int FRAME_BYTES   = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PCL,
    ST_ACK,
    ST_SR,
    ST_PCH,
    ST_VLO,
    ST_VHI,
    ST_CHK
  } step_e;

  function automatic lvl_t sr_mask(word_t sr);
    return sr[SR_MASK_LSB +: LVL_W];
  endfunction

  function automatic word_t entry_sr(word_t sr, lvl_t lvl);
    word_t r;
    r = sr;
    r[SR_T_BIT] = 1'b0;
    r[SR_S_BIT] = 1'b1;
    r[SR_MASK_LSB +: LVL_W] = lvl;
    return r;
  endfunction

  function automatic addr_t autovec_addr(addr_t base, lvl_t lvl);
    return base + ((addr_t'(AUTOVEC_FIRST) + addr_t'(lvl)) << 2);
  endfunction

  function automatic addr_t ack_addr(lvl_t lvl);
    addr_t a;
    a = '1;
    a[3:0] = {lvl, 1'b1};
    return a;
  endfunction

  function automatic addr_t push_addr(addr_t sp, step_e st);
    case (st)
      ST_PCL:  return sp - addr_t'(2);
      ST_SR:   return sp - addr_t'(FRAME_BYTES);
      ST_PCH:  return sp - addr_t'(4);
      default: return sp;
    endcase
  endfunction

  function automatic logic is_bus_step(step_e st);
    return (st != ST_IDLE) && (st != ST_CHK);
  endfunction

endpackage

// File: rtl/irq_take_cmp.sv
module irq_take_cmp
  import irq_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_t level_i,
  input  lvl_t mask_i,
  input  logic nmi_clr_i,
  output logic take_o
);

  logic top_now;
  logic top_q;
  logic top_rise;
  logic nmi_q;

  assign top_now  = (level_i == '1);
  assign top_rise = top_now & ~top_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      top_q <= top_now;
      nmi_q <= (nmi_q | top_rise) & ~nmi_clr_i;
    end
  end

  assign take_o = (level_i > mask_i) | nmi_q | top_rise;

  // R2
  top_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_now && !$past(top_now)) |-> take_o);

endmodule

// File: rtl/irq_step_fsm.sv
module irq_step_fsm
  import irq_entry_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_i,
  input  logic  chain_i,
  input  logic  bus_done_i,
  output step_e state_o
);

  step_e state_q;
  step_e state_n;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE: if (go_i)       state_n = ST_PCL;
      ST_PCL:  if (bus_done_i) state_n = ST_ACK;
      ST_ACK:  if (bus_done_i) state_n = ST_SR;
      ST_SR:   if (bus_done_i) state_n = ST_PCH;
      ST_PCH:  if (bus_done_i) state_n = ST_VLO;
      ST_VLO:  if (bus_done_i) state_n = ST_VHI;
      ST_VHI:  if (bus_done_i) state_n = ST_CHK;
      ST_CHK:  state_n = chain_i ? ST_PCL : ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign state_o = state_q;

  // R4
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bus_step(state_q) && !bus_done_i) |=> $stable(state_q));

endmodule

// File: rtl/irq_frame_regs.sv
module irq_frame_regs
  import irq_entry_pkg::*;
#(
  parameter addr_t VEC_BASE = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  step_e state_i,
  input  logic  load_i,
  input  logic  chain_i,
  input  logic  bus_done_i,
  input  word_t bus_rdata_i,
  input  lvl_t  level_i,
  input  word_t sr_i,
  input  addr_t sp_i,
  input  addr_t pc_i,
  output logic  bus_req_o,
  output logic  bus_we_o,
  output logic  bus_ack_o,
  output addr_t bus_addr_o,
  output word_t bus_wdata_o,
  output addr_t handler_o,
  output word_t sr_new_o,
  output addr_t sp_new_o,
  output lvl_t  lvl_o
);

  lvl_t  lvl_q;
  word_t sr_q;
  addr_t sp_q;
  addr_t pc_q;
  word_t vlo_q;
  word_t vhi_q;
  addr_t vec_a;
  addr_t hnd;
  word_t sr_nx;
  addr_t sp_nx;

  assign vec_a = autovec_addr(VEC_BASE, lvl_q);
  assign hnd   = {vhi_q, vlo_q};
  assign sr_nx = entry_sr(sr_q, lvl_q);
  assign sp_nx = sp_q - addr_t'(FRAME_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      sr_q  <= '0;
      sp_q  <= '0;
      pc_q  <= '0;
      vlo_q <= '0;
      vhi_q <= '0;
    end else begin
      if (load_i) begin
        lvl_q <= level_i;
        sr_q  <= sr_i;
        sp_q  <= sp_i;
        pc_q  <= pc_i;
      end else if (chain_i) begin
        lvl_q <= level_i;
        sr_q  <= sr_nx;
        sp_q  <= sp_nx;
        pc_q  <= hnd;
      end
      if (bus_done_i && state_i == ST_VLO) vlo_q <= bus_rdata_i;
      if (bus_done_i && state_i == ST_VHI) vhi_q <= bus_rdata_i;
    end
  end

  always_comb begin
    bus_req_o   = is_bus_step(state_i);
    bus_we_o    = 1'b0;
    bus_ack_o   = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    case (state_i)
      ST_PCL: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = push_addr(sp_q, ST_PCL);
        bus_wdata_o = pc_q[WORD_W-1:0];
      end
      ST_ACK: begin
        bus_ack_o  = 1'b1;
        bus_addr_o = ack_addr(lvl_q);
      end
      ST_SR: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = push_addr(sp_q, ST_SR);
        bus_wdata_o = sr_q;
      end
      ST_PCH: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = push_addr(sp_q, ST_PCH);
        bus_wdata_o = pc_q[ADDR_W-1:WORD_W];
      end
      ST_VLO:  bus_addr_o = vec_a + addr_t'(2);
      ST_VHI:  bus_addr_o = vec_a;
      default: ;
    endcase
  end

  assign handler_o = hnd;
  assign sr_new_o  = sr_nx;
  assign sp_new_o  = sp_nx;
  assign lvl_o     = lvl_q;

  // R5
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_bus_step(state_i) |=> ($stable(lvl_q) && $stable(sp_q) && $stable(pc_q)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary_i,
  input  logic [2:0]  level_i,
  input  logic [15:0] sr_i,
  input  logic [31:0] sp_i,
  input  logic [31:0] pc_i,
  input  logic        one_insn_i,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic        bus_ack_o,
  output logic [31:0] bus_addr_o,
  output logic [15:0] bus_wdata_o,
  input  logic [15:0] bus_rdata_i,
  input  logic        bus_done_i,
  output logic        busy_o,
  output logic        entry_done_o,
  output logic [31:0] handler_o,
  output logic [15:0] sr_o,
  output logic [31:0] sp_o
);

  step_e state;
  lvl_t  cur_lvl;
  lvl_t  cmp_mask;
  logic  take;
  logic  start_evt;
  logic  chain_evt;
  word_t sr_new;

  assign cmp_mask  = (state == ST_IDLE) ? sr_mask(sr_i) : sr_mask(sr_new);
  assign start_evt = (state == ST_IDLE) & boundary_i & take;
  assign chain_evt = (state == ST_CHK) & take & ~one_insn_i;

  irq_take_cmp u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (level_i),
    .mask_i    (cmp_mask),
    .nmi_clr_i ((start_evt | chain_evt) & (level_i == '1)),
    .take_o    (take)
  );

  irq_step_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (start_evt),
    .chain_i    (chain_evt),
    .bus_done_i (bus_done_i),
    .state_o    (state)
  );

  irq_frame_regs #(.VEC_BASE(VEC_BASE)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state),
    .load_i      (start_evt),
    .chain_i     (chain_evt),
    .bus_done_i  (bus_done_i),
    .bus_rdata_i (bus_rdata_i),
    .level_i     (level_i),
    .sr_i        (sr_i),
    .sp_i        (sp_i),
    .pc_i        (pc_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_ack_o   (bus_ack_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .handler_o   (handler_o),
    .sr_new_o    (sr_new),
    .sp_new_o    (sp_o),
    .lvl_o       (cur_lvl)
  );

  assign sr_o         = sr_new;
  assign busy_o       = (state != ST_IDLE);
  assign entry_done_o = (state == ST_CHK) & ~chain_evt;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_done_i) |=> (bus_req_o && $stable(bus_addr_o)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done_o |=> !busy_o);

  // R1
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(boundary_i));

  // R8
  one_insn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_insn_i && state == ST_CHK) |-> entry_done_o);

  // R3
  ack_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_o |-> (bus_addr_o[3:1] == cur_lvl));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

  localparam int CLK_P = 10;
  localparam logic [31:0] VB = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0;
  logic [2:0]  level_i = '0;
  logic [15:0] sr_i = '0;
  logic [31:0] sp_i = '0;
  logic [31:0] pc_i = '0;
  logic        one_insn_i = 1'b0;
  logic        bus_req_o, bus_we_o, bus_ack_o;
  logic [31:0] bus_addr_o;
  logic [15:0] bus_wdata_o;
  logic [15:0] bus_rdata_i = '0;
  logic        bus_done_i = 1'b0;
  logic        busy_o, entry_done_o;
  logic [31:0] handler_o, sp_o;
  logic [15:0] sr_o;

  always #(CLK_P/2) clk = ~clk;

  irq_entry_seq #(.VEC_BASE(VB)) u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .level_i(level_i),
    .sr_i(sr_i), .sp_i(sp_i), .pc_i(pc_i), .one_insn_i(one_insn_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_ack_o(bus_ack_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i), .bus_done_i(bus_done_i), .busy_o(busy_o),
    .entry_done_o(entry_done_o), .handler_o(handler_o), .sr_o(sr_o), .sp_o(sp_o)
  );

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wcnt = 0;
  int lg_n = 0;
  int done_n = 0;
  logic [31:0] lg_addr [0:31];
  logic [15:0] lg_data [0:31];
  logic        lg_we   [0:31];
  logic        lg_ack  [0:31];
  logic [31:0] dn_hnd = '0, dn_sp = '0;
  logic [15:0] dn_sr = '0;

  function automatic logic [15:0] rd_word(logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] vec_of(logic [2:0] l);
    return VB + 32'(4 * (24 + int'(l)));
  endfunction

  function automatic logic [31:0] hnd_of(logic [2:0] l);
    return {rd_word(vec_of(l)), rd_word(vec_of(l) + 32'd2)};
  endfunction

  function automatic logic [15:0] nsr_of(logic [15:0] s, logic [2:0] l);
    return (s & 16'h78FF) | 16'h2000 | (16'(l) << 8);
  endfunction

  always @(negedge clk) begin
    if (entry_done_o) begin
      done_n = done_n + 1;
      dn_hnd = handler_o;
      dn_sp  = sp_o;
      dn_sr  = sr_o;
    end
    if (bus_done_i) begin
      bus_done_i = 1'b0;
      wcnt = 0;
    end else if (bus_req_o) begin
      if (wcnt >= lat) begin
        bus_done_i  = 1'b1;
        bus_rdata_i = bus_we_o ? 16'h0 : rd_word(bus_addr_o);
        if (lg_n < 32) begin
          lg_addr[lg_n] = bus_addr_o;
          lg_data[lg_n] = bus_wdata_o;
          lg_we[lg_n]   = bus_we_o;
          lg_ack[lg_n]  = bus_ack_o;
          lg_n = lg_n + 1;
        end
      end else begin
        wcnt = wcnt + 1;
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_boundary();
    boundary_i = 1'b1;
    cyc(1);
    boundary_i = 1'b0;
  endtask

  task automatic wait_done(input int target, input int maxc);
    for (int i = 0; i < maxc && done_n < target; i++) cyc(1);
  endtask

  task automatic verify_frame(input int b, input logic [31:0] pc, input logic [15:0] sr,
                              input logic [31:0] sp, input logic [2:0] l);
    logic [31:0] v;
    v = vec_of(l);
    check(lg_n >= b + 6, "R3 cycle count", 32'(lg_n), 32'(b + 6));
    if (lg_n >= b + 6) begin
      check(lg_addr[b] == sp - 2 && lg_we[b] && !lg_ack[b] && lg_data[b] == pc[15:0],
            "R3 pc low push", lg_addr[b], sp - 2);
      check(lg_addr[b+1] == {28'hFFFFFFF, l, 1'b1} && !lg_we[b+1] && lg_ack[b+1],
            "R3 acknowledge", lg_addr[b+1], {28'hFFFFFFF, l, 1'b1});
      check(lg_addr[b+2] == sp - 6 && lg_we[b+2] && lg_data[b+2] == sr,
            "R3 sr push", {lg_addr[b+2][15:0], lg_data[b+2]}, {sp[15:0] - 16'd6, sr});
      check(lg_addr[b+3] == sp - 4 && lg_we[b+3] && lg_data[b+3] == pc[31:16],
            "R3 pc high push", lg_addr[b+3], sp - 4);
      check(lg_addr[b+4] == v + 2 && !lg_we[b+4] && !lg_ack[b+4],
            "R3 vector low read", lg_addr[b+4], v + 2);
      check(lg_addr[b+5] == v && !lg_we[b+5] && !lg_ack[b+5],
            "R3 vector high read", lg_addr[b+5], v);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    logic [31:0] pc, sp, h1;
    logic [15:0] sr, s1;
    cyc(3);
    // R9 reset state
    check(!busy_o && !bus_req_o && !entry_done_o, "R9 during reset",
          {29'd0, busy_o, bus_req_o, entry_done_o}, 32'd0);
    rst_n = 1'b1;
    cyc(2);
    check(!busy_o && !bus_req_o && !entry_done_o, "R9 after reset",
          {29'd0, busy_o, bus_req_o, entry_done_o}, 32'd0);

    // R1 level above mask without a boundary does nothing
    sr_i = 16'h0000; level_i = 3'd5; lg_n = 0;
    cyc(10);
    check(lg_n == 0 && !busy_o, "R1 no boundary", 32'(lg_n), 32'd0);
    level_i = 3'd0;
    cyc(2);

    // R1 R2 R3 R4 R6 sweep of mask against level
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 8; l++) begin
        lat = (m + l) % 3;
        sr = 16'(m << 8) | 16'(((l % 2) == 1) ? 16'h8000 : 16'h0000) | 16'h0015;
        pc = 32'h00A0_0000 + 32'((m * 8 + l) * 18);
        sp = 32'h0004_0000 - 32'((m * 8 + l) * 32);
        level_i = 3'd0;
        cyc(2);
        sr_i = sr; pc_i = pc; sp_i = sp; level_i = 3'(l);
        lg_n = 0; d0 = done_n;
        cyc(1);
        pulse_boundary();
        if (l > m || l == 7) begin
          wait_done(d0 + 1, 60);
          check(done_n == d0 + 1, "R1 taken", 32'(done_n - d0), 32'd1);
          verify_frame(0, pc, sr, sp, 3'(l));
          check(dn_hnd == hnd_of(3'(l)), "R6 handler", dn_hnd, hnd_of(3'(l)));
          check(dn_sp == sp - 6, "R6 stack pointer", dn_sp, sp - 6);
          check(dn_sr == nsr_of(sr, 3'(l)), "R6 status", {16'd0, dn_sr}, {16'd0, nsr_of(sr, 3'(l))});
          cyc(1);
          check(!busy_o, "R6 idle after", {31'd0, busy_o}, 32'd0);
        end else begin
          cyc(10);
          check(lg_n == 0 && done_n == d0, "R1 not taken", 32'(lg_n), 32'd0);
        end
      end
    end
    level_i = 3'd0;
    cyc(2);

    // R5 R7 chained entry: level rises mid-sequence
    lat = 1; sr = 16'h0004; pc = 32'h0012_3456; sp = 32'h0003_0000;
    sr_i = sr; pc_i = pc; sp_i = sp; level_i = 3'd2;
    lg_n = 0; d0 = done_n;
    cyc(1);
    pulse_boundary();
    cyc(3);
    level_i = 3'd5;
    wait_done(d0 + 1, 120);
    cyc(3);
    check(done_n == d0 + 1, "R7 single completion", 32'(done_n - d0), 32'd1);
    check(lg_n == 12, "R7 twelve cycles", 32'(lg_n), 32'd12);
    verify_frame(0, pc, sr, sp, 3'd2);
    h1 = hnd_of(3'd2); s1 = nsr_of(sr, 3'd2);
    verify_frame(6, h1, s1, sp - 6, 3'd5);
    check(dn_hnd == hnd_of(3'd5), "R7 nested handler", dn_hnd, hnd_of(3'd5));
    check(dn_sp == sp - 12, "R7 nested sp", dn_sp, sp - 12);
    check(dn_sr == nsr_of(s1, 3'd5), "R7 nested sr", {16'd0, dn_sr}, {16'd0, nsr_of(s1, 3'd5)});
    level_i = 3'd0;
    cyc(2);

    // R8 one-instruction mode
    one_insn_i = 1'b1;
    sr_i = sr; pc_i = pc; sp_i = sp; level_i = 3'd2;
    lg_n = 0; d0 = done_n;
    cyc(1);
    pulse_boundary();
    cyc(3);
    level_i = 3'd5;
    wait_done(d0 + 1, 120);
    cyc(5);
    check(done_n == d0 + 1 && lg_n == 6, "R8 no chain", 32'(lg_n), 32'd6);
    check(dn_hnd == h1 && dn_sr == s1, "R8 first handler", dn_hnd, h1);
    sr_i = dn_sr; pc_i = dn_hnd; sp_i = dn_sp;
    pulse_boundary();
    wait_done(d0 + 2, 60);
    check(done_n == d0 + 2, "R8 taken at next boundary", 32'(done_n - d0), 32'd2);
    verify_frame(6, h1, s1, sp - 6, 3'd5);
    one_insn_i = 1'b0;
    level_i = 3'd0;
    cyc(2);

    // R2 level 7 taken once per arrival
    lat = 0; sr_i = 16'h2700; pc_i = 32'h0000_4000; sp_i = 32'h0002_0000;
    level_i = 3'd7; lg_n = 0; d0 = done_n;
    cyc(1);
    pulse_boundary();
    wait_done(d0 + 1, 60);
    check(done_n == d0 + 1, "R2 top level taken", 32'(done_n - d0), 32'd1);
    cyc(2);
    lg_n = 0;
    pulse_boundary();
    cyc(15);
    check(lg_n == 0 && done_n == d0 + 1, "R2 held level ignored", 32'(lg_n), 32'd0);
    level_i = 3'd0;
    cyc(2);
    level_i = 3'd7;
    cyc(1);
    pulse_boundary();
    wait_done(d0 + 2, 60);
    check(done_n == d0 + 2, "R2 new arrival taken", 32'(done_n - d0), 32'd2);
    verify_frame(0, 32'h0000_4000, 16'h2700, 32'h0002_0000, 3'd7);
    level_i = 3'd0;
    cyc(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule